// File: doc/BRIEF.md
# Indexed RTC Register Port with Interrupt Flags

This block is the host-facing register file of a real-time clock. The host sees two addresses. A write to the even address picks one of 128 byte locations. An access to the odd address then reads or writes the picked byte. Four locations are control registers:

- A holds the periodic rate select.
- B holds the interrupt enables and mode bits.
- C holds the interrupt flags and clears when read.
- D holds a fixed status value.

The remaining locations are plain storage. This includes the time and alarm bytes, which an external counter maintains.

Three flag sources arrive from outside as one-cycle pulses: the periodic divider, the update-ended event and the alarm comparator. Each pulse latches a flag in register C. When a newly latched flag has its enable bit set in register B, the summary flag is set and the active-high interrupt line is raised. The line stays high until the host reads register C, or until a write to register B leaves no enabled flag pending.

The block drives the rate select and the periodic enable out to the external divider. It also pulses a restart strobe whenever either of these settings changes, so that the divider can realign its phase.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address stores wdata[6:0] as the index; bit 7 is discarded. A read of the even address returns 0xFF.
- R2: An odd-address write stores the byte at the selected index, and a later odd-address read at that index returns it. This applies to every index other than the control registers A (0x0A), B (0x0B), C (0x0C) and D (0x0D).
- R3: After reset, register A reads 0x26, B reads 0x02, C reads 0x00 and D reads 0x80. After reset, irq is 0, rate_sel is 6 and periodic_en is 0.
- R4: A periodic, alarm or update pulse sets flag bit 6, 5 or 4 of register C respectively, whatever the enables. If the flag was clear and its enable (B bit 6, 5 or 4) is 1, C bit 7 is set and irq is high from the next cycle.
- R5: A read of register C returns its current value. The register then becomes 0x00 and irq is low from the next cycle.
- R6: A flag pulse that arrives in the same cycle as a read of register C is kept. The next read of register C returns it.
- R7: A write to register B raises irq when any of the new value's bits 6..4 matches a flag already set. Otherwise the write clears C bit 7 and lowers irq. The flags themselves are kept.
- R8: Writes to registers C and D are ignored. Bit 7 of register A always reads 0 and cannot be written.
- R9: A write to register B with bit 7 set stores bit 4 as 0.
- R10: rate_sel follows A[3:0] and periodic_en follows B[6]. periodic_restart pulses for one cycle after a write that changes A[3:0] or B[6], and stays low after a write that changes neither.
- R11: A cycle with soft_rst high clears B bits 6, 5 and 3 and the whole of register C, and lowers irq.
- R12: An odd-address access at index 0x32 acts on location 0x37 and redirects the index to 0x37.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| soft_rst | input | 1 | Device reset of enables and flags |
| acc_en | input | 1 | Host access strobe |
| acc_we | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 1 | 0 selects index, 1 selects data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while a read access is presented |
| tick_periodic | input | 1 | Periodic divider pulse |
| tick_alarm | input | 1 | Alarm match pulse |
| tick_update | input | 1 | Update-ended pulse |
| irq | output | 1 | Active-high interrupt level |
| rate_sel | output | 4 | Periodic rate select to the divider |
| periodic_en | output | 1 | Periodic interrupt enable to the divider |
| periodic_restart | output | 1 | One-cycle strobe to restart periodic timing |

## Verification
The flag logic is driven three ways:

- Each source alone, with its enable off and then on. This separates a latched flag from a raised interrupt.
- A pulse coincident with a read of register C. This shows whether the clear-on-read erases a fresh event.
- A flag left pending while register B is rewritten. This tells the immediate-assert path apart from the clear path.

The register map is probed with writes to the read-only locations and bits, an index above 127 and the aliased index. Those probes confirm that the decode, not the storage, shapes each result.

// File: rtl/rtc_regport.sv
module rtc_regport #(
  parameter int IDX_W = 7,
  parameter logic [6:0] ALIAS_IDX = 7'h32,
  parameter logic [6:0] CENTURY_IDX = 7'h37
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       acc_en,
  input  logic       acc_we,
  input  logic       acc_addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick_periodic,
  input  logic       tick_alarm,
  input  logic       tick_update,
  output logic       irq,
  output logic [3:0] rate_sel,
  output logic       periodic_en,
  output logic       periodic_restart
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] R_A = IDX_W'(8'h0A);
  localparam logic [IDX_W-1:0] R_B = IDX_W'(8'h0B);
  localparam logic [IDX_W-1:0] R_C = IDX_W'(8'h0C);
  localparam logic [IDX_W-1:0] R_D = IDX_W'(8'h0D);
  localparam logic [7:0] A_INIT = 8'h26;
  localparam logic [7:0] B_INIT = 8'h02;
  localparam logic [7:0] D_FIXED = 8'h80;
  localparam logic [7:0] B_SOFT_KEEP = 8'h97;

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] idx, sel;
  logic [7:0]       reg_a, reg_b, b_new;
  logic [2:0]       c_flags, tick;
  logic             c_irqf;

  assign sel = (idx == IDX_W'(ALIAS_IDX)) ? IDX_W'(CENTURY_IDX) : idx;

  wire idx_wr  = acc_en &&  acc_we && !acc_addr;
  wire dat_wr  = acc_en &&  acc_we &&  acc_addr;
  wire dat_rd  = acc_en && !acc_we &&  acc_addr;
  wire a_wr    = dat_wr && sel == R_A;
  wire b_wr    = dat_wr && sel == R_B;
  wire c_rd    = dat_rd && sel == R_C;
  wire is_ctrl = sel == R_A || sel == R_B || sel == R_C || sel == R_D;

  assign tick  = {tick_periodic, tick_alarm, tick_update};
  assign b_new = wdata[7] ? (wdata & 8'hEF) : wdata;

  wire [2:0] fresh  = tick & ~c_flags;
  wire       raise  = |(fresh & reg_b[6:4]);
  wire       b_hit  = |(b_new[6:4] & (c_flags | tick));
  wire       rd_hit = |(tick & reg_b[6:4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx              <= '0;
      reg_a            <= A_INIT;
      reg_b            <= B_INIT;
      c_flags          <= '0;
      c_irqf           <= 1'b0;
      periodic_restart <= 1'b0;
    end else begin
      if (idx_wr)
        idx <= wdata[IDX_W-1:0];
      else if (acc_en && acc_addr && idx == IDX_W'(ALIAS_IDX))
        idx <= IDX_W'(CENTURY_IDX);

      if (a_wr)
        reg_a <= {1'b0, wdata[6:0]};

      periodic_restart <= (a_wr && wdata[3:0] != reg_a[3:0]) ||
                          (b_wr && !soft_rst && b_new[6] != reg_b[6]) ||
                          (soft_rst && reg_b[6]);

      if (soft_rst) begin
        reg_b   <= (b_wr ? b_new : reg_b) & B_SOFT_KEEP;
        c_flags <= '0;
        c_irqf  <= 1'b0;
      end else begin
        if (b_wr)
          reg_b <= b_new;
        if (c_rd) begin
          c_flags <= tick;
          c_irqf  <= rd_hit;
        end else begin
          c_flags <= c_flags | tick;
          c_irqf  <= b_wr ? b_hit : (c_irqf | raise);
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (dat_wr && !is_ctrl)
      mem[sel] <= wdata;

  always_comb begin
    rdata = 8'h00;
    if (acc_en && !acc_we && !acc_addr)
      rdata = 8'hFF;
    else if (dat_rd)
      case (sel)
        R_A:     rdata = reg_a;
        R_B:     rdata = reg_b;
        R_C:     rdata = {c_irqf, c_flags, 4'b0000};
        R_D:     rdata = D_FIXED;
        default: rdata = mem[sel];
      endcase
  end

  assign irq         = c_irqf;
  assign rate_sel    = reg_a[3:0];
  assign periodic_en = reg_b[6];
endmodule

module rtc_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       acc_en,
  input logic       acc_we,
  input logic       acc_addr,
  input logic [6:0] sel,
  input logic [7:0] rdata,
  input logic       tick_periodic,
  input logic       tick_alarm,
  input logic       tick_update,
  input logic       periodic_en,
  input logic       irq
);
  wire any_tick = tick_periodic || tick_alarm || tick_update;
  wire data_wr  = acc_en && acc_we && acc_addr;
  wire c_read   = acc_en && !acc_we && acc_addr && sel == 7'h0C;

  assert_even_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !acc_we && !acc_addr |-> rdata == 8'hFF);

  assert_pf_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_periodic && periodic_en && !soft_rst && !data_wr |=> irq);

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    c_read && !any_tick && !soft_rst |=> !irq);

  assert_c_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && sel == 7'h0C && !any_tick && !soft_rst |=> irq == $past(irq));

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !irq && !periodic_en);
endmodule

bind rtc_regport rtc_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .acc_en(acc_en),
  .acc_we(acc_we), .acc_addr(acc_addr), .sel(sel), .rdata(rdata),
  .tick_periodic(tick_periodic), .tick_alarm(tick_alarm),
  .tick_update(tick_update), .periodic_en(periodic_en), .irq(irq)
);

// File: tb/test_rtc_regport.sv
module test_rtc_regport;
  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic acc_en = 0, acc_we = 0, acc_addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic tp = 0, ta = 0, tu = 0;
  logic irq, periodic_en, periodic_restart;
  logic [3:0] rate_sel;
  int n_chk = 0, n_fail = 0;
  logic done = 0;
  logic [7:0] rv;
  logic rst_seen;

  always #2 clk = ~clk;

  rtc_regport i_rtc_regport (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .acc_en(acc_en),
    .acc_we(acc_we), .acc_addr(acc_addr), .wdata(wdata), .rdata(rdata),
    .tick_periodic(tp), .tick_alarm(ta), .tick_update(tu), .irq(irq),
    .rate_sel(rate_sel), .periodic_en(periodic_en),
    .periodic_restart(periodic_restart));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic access(logic we, logic ad, logic [7:0] d, logic p, logic a, logic u);
    @(negedge clk);
    acc_en = 1; acc_we = we; acc_addr = ad; wdata = d; tp = p; ta = a; tu = u;
    #1 rv = rdata;
    @(negedge clk);
    acc_en = 0; tp = 0; ta = 0; tu = 0;
    rst_seen = periodic_restart;
  endtask

  task automatic sel_idx(logic [7:0] i); access(1, 0, i, 0, 0, 0); endtask
  task automatic wr_reg(logic [7:0] i, logic [7:0] d);
    sel_idx(i); access(1, 1, d, 0, 0, 0);
  endtask
  task automatic rd_reg(logic [7:0] i); sel_idx(i); access(0, 1, 0, 0, 0, 0); endtask
  task automatic pulse(logic p, logic a, logic u);
    @(negedge clk); tp = p; ta = a; tu = u;
    @(negedge clk); tp = 0; ta = 0; tu = 0;
  endtask

  task automatic t_reset;
    check("R3 irq", {7'b0, irq}, 0);
    check("R3 rate_sel", {4'b0, rate_sel}, 8'h06);
    check("R3 periodic_en", {7'b0, periodic_en}, 0);
    rd_reg(8'h0A); check("R3 A", rv, 8'h26);
    rd_reg(8'h0B); check("R3 B", rv, 8'h02);
    rd_reg(8'h0C); check("R3 C", rv, 8'h00);
    rd_reg(8'h0D); check("R3 D", rv, 8'h80);
  endtask

  task automatic t_index;
    access(0, 0, 0, 0, 0, 0); check("R1 even read", rv, 8'hFF);
    wr_reg(8'h95, 8'h5A);
    wr_reg(8'h20, 8'h33);
    rd_reg(8'h15); check("R1 index bit7 dropped", rv, 8'h5A);
    rd_reg(8'h20); check("R2 ram readback", rv, 8'h33);
  endtask

  task automatic t_flags;
    wr_reg(8'h0B, 8'h02);
    pulse(1, 0, 0); check("R4 no enable irq", {7'b0, irq}, 0);
    rd_reg(8'h0C); check("R4 PF latched", rv, 8'h40);
    rd_reg(8'h0C); check("R5 cleared", rv, 8'h00);
    wr_reg(8'h0B, 8'h42);
    pulse(1, 0, 0); check("R4 PIE irq", {7'b0, irq}, 1);
    rd_reg(8'h0C); check("R4 PF+IRQF", rv, 8'hC0);
    check("R5 irq drops", {7'b0, irq}, 0);
    wr_reg(8'h0B, 8'h22);
    pulse(0, 1, 0); rd_reg(8'h0C); check("R4 AF+IRQF", rv, 8'hA0);
    wr_reg(8'h0B, 8'h12);
    pulse(0, 0, 1); check("R4 UIE irq", {7'b0, irq}, 1);
    rd_reg(8'h0C); check("R4 UF+IRQF", rv, 8'h90);
  endtask

  task automatic t_coincide;
    wr_reg(8'h0B, 8'h02);
    sel_idx(8'h0C); access(0, 1, 0, 0, 0, 1);
    check("R6 read value", rv, 8'h00);
    access(0, 1, 0, 0, 0, 0); check("R6 kept flag", rv, 8'h10);
  endtask

  task automatic t_benable;
    wr_reg(8'h0B, 8'h02);
    pulse(0, 1, 0); check("R7 pending no irq", {7'b0, irq}, 0);
    wr_reg(8'h0B, 8'h22); check("R7 enable raises", {7'b0, irq}, 1);
    wr_reg(8'h0B, 8'h02); check("R7 disable lowers", {7'b0, irq}, 0);
    rd_reg(8'h0C); check("R7 flag kept irqf clear", rv, 8'h20);
  endtask

  task automatic t_readonly;
    wr_reg(8'h0C, 8'hFF); check("R8 C write irq", {7'b0, irq}, 0);
    rd_reg(8'h0C); check("R8 C write ignored", rv, 8'h00);
    wr_reg(8'h0D, 8'h00); rd_reg(8'h0D); check("R8 D write ignored", rv, 8'h80);
    wr_reg(8'h0A, 8'hA5); rd_reg(8'h0A); check("R8 A bit7", rv, 8'h25);
  endtask

  task automatic t_set;
    wr_reg(8'h0B, 8'h92); rd_reg(8'h0B); check("R9 set clears UIE", rv, 8'h82);
  endtask

  task automatic t_restart;
    wr_reg(8'h0B, 8'h02);
    wr_reg(8'h0A, 8'h2A); check("R10 A nibble change", {7'b0, rst_seen}, 1);
    check("R10 rate_sel", {4'b0, rate_sel}, 8'h0A);
    wr_reg(8'h0A, 8'h3A); check("R10 A same nibble", {7'b0, rst_seen}, 0);
    wr_reg(8'h0B, 8'h42); check("R10 PIE change", {7'b0, rst_seen}, 1);
    check("R10 periodic_en", {7'b0, periodic_en}, 1);
    wr_reg(8'h0B, 8'h46); check("R10 B other bit", {7'b0, rst_seen}, 0);
  endtask

  task automatic t_soft;
    wr_reg(8'h0B, 8'h7A);
    pulse(1, 0, 0); check("R11 pre irq", {7'b0, irq}, 1);
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    check("R11 irq low", {7'b0, irq}, 0);
    rd_reg(8'h0B); check("R11 B enables", rv, 8'h12);
    rd_reg(8'h0C); check("R11 C cleared", rv, 8'h00);
  endtask

  task automatic t_alias;
    sel_idx(8'h32); access(1, 1, 8'h20, 0, 0, 0); access(1, 1, 8'h21, 0, 0, 0);
    rd_reg(8'h37); check("R12 century written", rv, 8'h21);
    rd_reg(8'h32); check("R12 alias read", rv, 8'h21);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_index; t_flags; t_coincide; t_benable;
    t_readonly; t_set; t_restart; t_soft; t_alias;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule